// File: doc/BRIEF.md
# Frame Readout Strobe Generator

This block paces the transfer of one frame of pixel words out of a FIFO into a downstream link card. A frame request starts the transfer with a single frame-start pulse. After a programmable lead time the block issues one read strobe per word for as long as the FIFO reports data. The FIFO uses that strobe as its read enable, and the downstream card uses the same strobe to qualify the data. The block samples the word on the trailing edge of each strobe. This leaves the whole strobe width for the FIFO access time, and the sampled word is presented with a one-cycle valid flag.

The frame-start width, the read-strobe width, the gap between strobes and the lead time are all inputs counted in clock cycles. Each value is raised to a floor derived from nanosecond minimums and the configured clock period, so software cannot program a pulse that is too narrow. A frame-done input ends the transfer and returns the block to idle, where it waits for the next request.

Top module: `frame_strobe_gen`

## Requirements
- R1: Each frame request accepted in idle produces exactly one frame-start pulse. The pulse is high for max(cfg_fs_width, MINP) cycles, where MINP = max(1, ceil(MIN_PULSE_PS / CLK_PERIOD_PS)).
- R2: Each read strobe is high for exactly max(cfg_rd_width, MINP) cycles, and frame_start and rd_strobe are never high together.
- R3: While the FIFO stays non-empty, the low time between two strobes of a frame is exactly max(cfg_gap, MING) cycles, where MING = max(1, ceil(MIN_GAP_PS / CLK_PERIOD_PS)). The low time is never shorter.
- R4: While the FIFO is non-empty, the first strobe of a frame rises exactly max(cfg_lead, MINL) cycles after frame_start falls, where MINL = max(1, ceil(MIN_LEAD_PS / CLK_PERIOD_PS)). The delay is never shorter.
- R5: A strobe starts only if fifo_empty (active high) was low at the previous clock edge. A frame with an empty FIFO produces no strobe, and a frame holding N words produces exactly N strobes.
- R6: In the first cycle after a strobe falls, word_valid is high for exactly one cycle. In that cycle word_out equals the fifo_data present at the edge that ended the strobe.
- R7: A frame_done seen between pulses returns the block to idle at the next edge with no further strobe. A frame_done seen during a pulse lets that pulse finish its full width, and the block then goes idle.
- R8: A frame_req that arrives while a frame is in progress is ignored and causes no second frame-start pulse.
- R9: After a synchronous reset, frame_start, rd_strobe and word_valid are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_req | input | 1 | Starts a frame when the block is idle |
| frame_done | input | 1 | Ends the current frame |
| fifo_empty | input | 1 | FIFO empty flag, high when no word is available |
| fifo_data | input | DATA_W | FIFO read data |
| cfg_fs_width | input | CNT_W | Frame-start width in cycles |
| cfg_rd_width | input | CNT_W | Read-strobe width in cycles |
| cfg_gap | input | CNT_W | Low time between strobes in cycles |
| cfg_lead | input | CNT_W | Low time from frame-start fall to the first strobe |
| frame_start | output | 1 | Frame-start pulse |
| rd_strobe | output | 1 | FIFO read enable and downstream data strobe |
| word_out | output | DATA_W | Word sampled at the strobe trailing edge |
| word_valid | output | 1 | One-cycle qualifier for word_out |

## Verification
A wrong timer load or an off-by-one in the clamp shows up as a pulse width, gap or lead time that differs by a cycle. The error appears on the very first pulse after the bad value is loaded. The sweep covers every setting at, below and above each floor, so a clamp fault shows at once. If the state machine misses the empty flag or frame_done, an extra or missing strobe appears within one gap time. A bad capture enable shows as a word_valid that does not coincide with a strobe falling edge, or as a word that does not match the FIFO contents in order.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FS, ST_WAIT, ST_STRB} fsg_state_e;

  // cycles needed to cover a duration, never below one
  function automatic int unsigned min_cycles(input int unsigned dur_ps,
                                             input int unsigned clk_ps);
    int unsigned c;
    c = (dur_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/fsg_clamp.sv
module fsg_clamp #(
  parameter int W    = 16,
  parameter int MINV = 1
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] eff
);
  localparam logic [W-1:0] FLOOR = W'(MINV);
  assign eff = (raw < FLOOR) ? FLOOR : raw;
endmodule

// File: rtl/fsg_downcnt.sv
module fsg_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/fsg_capture.sv
module fsg_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= en;
      if (en) dout <= din;
    end
  end
endmodule

// File: rtl/frame_strobe_gen.sv
module frame_strobe_gen
  import fsg_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int CNT_W         = 16,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int MIN_PULSE_PS  = 40000,
  parameter int MIN_GAP_PS    = 120000,
  parameter int MIN_LEAD_PS   = 21600000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_req,
  input  logic              frame_done,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [CNT_W-1:0]  cfg_fs_width,
  input  logic [CNT_W-1:0]  cfg_rd_width,
  input  logic [CNT_W-1:0]  cfg_gap,
  input  logic [CNT_W-1:0]  cfg_lead,
  output logic              frame_start,
  output logic              rd_strobe,
  output logic [DATA_W-1:0] word_out,
  output logic              word_valid
);
  localparam int MINP = int'(min_cycles(MIN_PULSE_PS, CLK_PERIOD_PS));
  localparam int MING = int'(min_cycles(MIN_GAP_PS, CLK_PERIOD_PS));
  localparam int MINL = int'(min_cycles(MIN_LEAD_PS, CLK_PERIOD_PS));

  logic [CNT_W-1:0] eff_fs, eff_rd, eff_gap, eff_lead;

  fsg_clamp #(.W(CNT_W), .MINV(MINP)) u_cl_fs   (.raw(cfg_fs_width), .eff(eff_fs));
  fsg_clamp #(.W(CNT_W), .MINV(MINP)) u_cl_rd   (.raw(cfg_rd_width), .eff(eff_rd));
  fsg_clamp #(.W(CNT_W), .MINV(MING)) u_cl_gap  (.raw(cfg_gap),      .eff(eff_gap));
  fsg_clamp #(.W(CNT_W), .MINV(MINL)) u_cl_lead (.raw(cfg_lead),     .eff(eff_lead));

  fsg_state_e       state, state_nx;
  logic             done_pend, done_pend_nx;
  logic             fs_nx, st_nx;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             cap_en;

  fsg_downcnt #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    state_nx     = state;
    done_pend_nx = done_pend;
    fs_nx        = frame_start;
    st_nx        = rd_strobe;
    tmr_load     = 1'b0;
    tmr_val      = '0;
    cap_en       = 1'b0;
    case (state)
      ST_IDLE: begin
        done_pend_nx = 1'b0;
        if (frame_req) begin
          state_nx = ST_FS;
          fs_nx    = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = eff_fs - 1'b1;
        end
      end
      ST_FS: begin
        if (frame_done) done_pend_nx = 1'b1;
        if (tmr_zero) begin
          fs_nx = 1'b0;
          if (done_pend || frame_done) begin
            state_nx = ST_IDLE;
          end else begin
            state_nx = ST_WAIT;
            tmr_load = 1'b1;
            tmr_val  = eff_lead - 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (frame_done) begin
          state_nx = ST_IDLE;
        end else if (tmr_zero && !fifo_empty) begin
          state_nx = ST_STRB;
          st_nx    = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = eff_rd - 1'b1;
        end
      end
      default: begin // ST_STRB
        if (frame_done) done_pend_nx = 1'b1;
        if (tmr_zero) begin
          st_nx  = 1'b0;
          cap_en = 1'b1;
          if (done_pend || frame_done) begin
            state_nx = ST_IDLE;
          end else begin
            state_nx = ST_WAIT;
            tmr_load = 1'b1;
            tmr_val  = eff_gap - 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      done_pend   <= 1'b0;
      frame_start <= 1'b0;
      rd_strobe   <= 1'b0;
    end else begin
      state       <= state_nx;
      done_pend   <= done_pend_nx;
      frame_start <= fs_nx;
      rd_strobe   <= st_nx;
    end
  end

  fsg_capture #(.W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .en(cap_en), .din(fifo_data),
    .dout(word_out), .valid(word_valid)
  );

  // ---------------- assertions and their observation counters ----------------
  logic [31:0] fs_hi, st_hi, lo_run;
  logic        last_fs;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_hi   <= '0;
      st_hi   <= '0;
      lo_run  <= '0;
      last_fs <= 1'b0;
    end else begin
      fs_hi  <= frame_start ? ((fs_hi == '1) ? fs_hi : fs_hi + 1) : '0;
      st_hi  <= rd_strobe   ? ((st_hi == '1) ? st_hi : st_hi + 1) : '0;
      lo_run <= (frame_start || rd_strobe) ? '0 :
                ((lo_run == '1) ? lo_run : lo_run + 1);
      if (frame_start)    last_fs <= 1'b1;
      else if (rd_strobe) last_fs <= 1'b0;
    end
  end

  AST_FS_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_start) |-> fs_hi >= 32'(MINP)); // R1

  AST_STROBE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_strobe) |-> st_hi >= 32'(MINP)); // R2

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(frame_start && rd_strobe)); // R2

  AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_strobe) && !last_fs) |-> lo_run >= 32'(MING)); // R3

  AST_LEAD_MIN: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_strobe) && last_fs) |-> lo_run >= 32'(MINL)); // R4

  AST_STROBE_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_strobe) |-> $past(!fifo_empty)); // R5

  AST_VALID_AT_TRAIL: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ($past(rd_strobe) && !rd_strobe)); // R6

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && frame_done) |=> (state == ST_IDLE && !rd_strobe)); // R7
endmodule

// File: tb/test_frame_strobe_gen.sv
`timescale 1ns/1ps
module test_frame_strobe_gen;
  localparam int DW = 16;
  localparam int CW = 8;
  // small configuration: 4 ns clock, floors of 2, 3 and 5 cycles
  localparam int MP = 2;
  localparam int MG = 3;
  localparam int ML = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_req = 1'b0;
  logic          frame_done = 1'b0;
  logic          fifo_empty;
  logic [DW-1:0] fifo_data;
  logic [CW-1:0] cfg_fs_width = '0, cfg_rd_width = '0, cfg_gap = '0, cfg_lead = '0;
  logic          frame_start, rd_strobe, word_valid;
  logic [DW-1:0] word_out;

  frame_strobe_gen #(
    .DATA_W(DW), .CNT_W(CW), .CLK_PERIOD_PS(4000),
    .MIN_PULSE_PS(6000), .MIN_GAP_PS(12000), .MIN_LEAD_PS(20000)
  ) i_frame_strobe_gen (
    .clk(clk), .rst(rst), .frame_req(frame_req), .frame_done(frame_done),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .cfg_fs_width(cfg_fs_width), .cfg_rd_width(cfg_rd_width),
    .cfg_gap(cfg_gap), .cfg_lead(cfg_lead),
    .frame_start(frame_start), .rd_strobe(rd_strobe),
    .word_out(word_out), .word_valid(word_valid)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // FIFO model
  logic [DW-1:0] mem [16];
  int rd_ptr = 0;
  int wr_cnt = 0;
  assign fifo_empty = (rd_ptr >= wr_cnt);
  assign fifo_data  = mem[rd_ptr[3:0]];

  // expectations and observations
  int exp_fs = MP, exp_rd = MP, exp_gap = MG, exp_lead = ML;
  bit exact = 1'b1;
  int words_seen = 0, fs_rises = 0, st_rises = 0;
  int fs_run = 0, st_run = 0, lo_run = 0;
  bit prev_fs = 0, prev_st = 0, prev_empty = 1, last_fs = 0;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int clampv(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  // monitor: samples 1 ns after the falling clock edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (mon_on) begin
        if (rd_strobe && !prev_st) begin
          st_rises++;
          chk(!prev_empty, "R5 strobe with empty fifo", 1, 0);
          if (last_fs) begin
            if (exact) chk(lo_run == exp_lead, "R4 lead", lo_run, exp_lead);
            else       chk(lo_run >= exp_lead, "R4 lead floor", lo_run, exp_lead);
          end else begin
            if (exact) chk(lo_run == exp_gap, "R3 gap", lo_run, exp_gap);
            else       chk(lo_run >= exp_gap, "R3 gap floor", lo_run, exp_gap);
          end
          last_fs = 0;
        end
        if (frame_start && !prev_fs) begin
          fs_rises++;
          last_fs = 1;
        end
        if (frame_start && rd_strobe) chk(0, "R2 overlap", 1, 0);
        if (!frame_start && prev_fs) begin
          chk(fs_run == exp_fs, "R1 frame_start width", fs_run, exp_fs);
          fs_run = 0;
        end
        if (!rd_strobe && prev_st) begin
          chk(st_run == exp_rd, "R2 strobe width", st_run, exp_rd);
          chk(word_valid == 1'b1, "R6 word_valid at trailing edge", int'(word_valid), 1);
          chk(word_out == mem[rd_ptr[3:0]], "R6 word_out", int'(word_out), int'(mem[rd_ptr[3:0]]));
          st_run = 0;
          rd_ptr++;
          words_seen++;
        end else if (word_valid) begin
          chk(0, "R6 spurious word_valid", 1, 0);
        end
        if (frame_start || rd_strobe) lo_run = 0; else lo_run++;
        if (frame_start) fs_run++;
        if (rd_strobe) st_run++;
      end
      prev_fs = frame_start;
      prev_st = rd_strobe;
      prev_empty = fifo_empty;
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        chk(0, "watchdog", cycles, 190000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic setup(input int fsw, input int sw, input int gp, input int ld,
                       input int nw, input int seed);
    cfg_fs_width = CW'(fsw); cfg_rd_width = CW'(sw);
    cfg_gap = CW'(gp);       cfg_lead = CW'(ld);
    exp_fs = clampv(fsw, MP); exp_rd = clampv(sw, MP);
    exp_gap = clampv(gp, MG); exp_lead = clampv(ld, ML);
    for (int i = 0; i < 16; i++) mem[i] = DW'(seed * 97 + i * 13 + 5);
    rd_ptr = 0; wr_cnt = nw;
    words_seen = 0; fs_rises = 0; st_rises = 0;
  endtask

  task automatic pulse_req();
    frame_req = 1'b1; @(negedge clk); frame_req = 1'b0;
  endtask

  task automatic pulse_done();
    frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 4000 && words_seen < n; i++) @(negedge clk);
  endtask

  task automatic run_frame(input int fsw, input int sw, input int gp, input int ld,
                           input int nw, input int seed);
    @(negedge clk);
    exact = 1'b1;
    setup(fsw, sw, gp, ld, nw, seed);
    pulse_req();
    wait_words(nw);
    repeat (exp_gap + exp_rd + 6) @(negedge clk);
    chk(words_seen == nw, "R5 strobes per frame", words_seen, nw);
    chk(st_rises == nw, "R5 strobe count", st_rises, nw);
    chk(fs_rises == 1, "R1 one frame_start", fs_rises, 1);
    pulse_done();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 1;
    repeat (4) @(negedge clk);
    #1;
    chk(frame_start == 0 && rd_strobe == 0 && word_valid == 0, "R9 reset outputs",
        int'({frame_start, rd_strobe, word_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    mon_on = 1;
    repeat (5) @(negedge clk);
    chk(fs_rises == 0 && st_rises == 0, "R9 idle after reset", fs_rises + st_rises, 0);

    // sweep of widths, gaps and leads around the floors
    for (int f = 0; f <= 3; f++)
      for (int s = 0; s <= 3; s++)
        for (int g = 1; g <= 5; g++)
          for (int li = 0; li < 4; li++) begin
            int lv;
            lv = (li == 0) ? 0 : (li == 1) ? 5 : (li == 2) ? 6 : 8;
            run_frame(f, s, g, lv, 3, seed);
            seed++;
          end

    // R5: empty FIFO stalls the frame; words arriving later are read
    @(negedge clk);
    setup(2, 2, 3, 5, 0, seed); exact = 1'b0;
    pulse_req();
    repeat (30) @(negedge clk);
    chk(st_rises == 0, "R5 no strobe while empty", st_rises, 0);
    wr_cnt = 2;
    wait_words(2);
    repeat (12) @(negedge clk);
    chk(words_seen == 2, "R5 late words read", words_seen, 2);
    pulse_done();
    repeat (3) @(negedge clk);
    exact = 1'b1;

    // R7: frame_done during a gap stops the frame at once
    setup(2, 2, 4, 5, 6, seed + 1);
    pulse_req();
    wait_words(2);
    pulse_done();
    repeat (30) @(negedge clk);
    chk(words_seen == 2, "R7 done in gap", words_seen, 2);
    chk(st_rises == 2, "R7 no strobe after done", st_rises, 2);

    // R7: frame_done during a strobe lets it finish its width
    setup(2, 4, 3, 5, 6, seed + 2);
    pulse_req();
    for (int i = 0; i < 200 && !rd_strobe; i++) @(negedge clk);
    pulse_done();
    repeat (30) @(negedge clk);
    chk(words_seen == 1, "R7 done in strobe", words_seen, 1);

    // R7: frame_done during frame_start: full pulse, no strobe
    setup(4, 2, 3, 5, 4, seed + 3);
    pulse_req();
    pulse_done();
    repeat (30) @(negedge clk);
    chk(fs_rises == 1, "R7 frame_start completes", fs_rises, 1);
    chk(st_rises == 0, "R7 no strobe after done in frame_start", st_rises, 0);

    // R8: frame_req while busy is ignored
    setup(2, 2, 5, 6, 4, seed + 4);
    pulse_req();
    wait_words(1);
    pulse_req();
    wait_words(4);
    repeat (20) @(negedge clk);
    chk(fs_rises == 1, "R8 request while busy ignored", fs_rises, 1);
    chk(words_seen == 4, "R8 frame unaffected", words_seen, 4);
    pulse_done();
    repeat (3) @(negedge clk);

    // a new frame after all of the above still runs to spec
    run_frame(3, 3, 4, 7, 4, seed + 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule